// File: doc/BRIEF.md
# Debug Instruction Injector

This block sits between a host and the debug port of a small pipelined processor core. It halts the core, feeds it instruction words while it is halted, and later lets it run again. The host loads words into an internal queue over a valid/ready push port. It raises a halt request, and the block then holds the core's force line high. Once the core reports that debug mode is active, the block drops the force line and reports the halted state.

While halted, the core pulls one word with each cycle of its fetch request. The core gives no valid qualifier, so the block always drives a legal word onto the instruction bus. That word is the queue head, or a no-op filler when the queue is empty. On a resume command the block places the breakpoint instruction behind any words still waiting. When the core consumes that word it leaves debug mode. The block reports running again once the core's enabled line falls.

Back-pressure rules: a word is taken on a clock edge where `host_valid` and `host_ready` are both high. `host_ready` is low while the queue is full, and from the accepted resume command until the core is running again.

Top module: `dbg_inject_ctrl`

## Requirements
- R1: After synchronous reset, `host_ready` is 1, `core_force`, `halted` and `busy` are 0, and `core_insn` carries the filler word (default 32'h00000013).
- R2: A `halt_req` sampled while running raises `core_force` and `busy` from the next cycle, with `halted` low. Both stay high until `core_enabled` is sampled high. `halted` and `busy` are never high together.
- R3: The cycle after `core_enabled` is sampled high during a halt, `halted` is 1 and `core_force` is 0.
- R4: If `core_enabled` rises while running with no halt request (a breakpoint executed by the core), the block enters the halted state the next cycle without ever raising `core_force`.
- R5: While the core is enabled, `core_insn` carries the oldest queued word. Each cycle with `core_fetch` high consumes exactly one word, in push order, however far apart the fetch cycles are.
- R6: With the queue empty (and no exit pending), `core_insn` carries the filler word and fetch cycles change nothing.
- R7: A queue of DEPTH words (default 8) drives `host_ready` low when full. A word offered then is not stored.
- R8: A `resume_cmd` sampled while halted queues the exit word 32'h00100073 behind all pending words. `host_ready` stays low from that point until running again.
- R9: After the exit word is consumed, `busy` stays high and `core_insn` returns to the filler. The cycle after `core_enabled` is sampled low, `busy` and `halted` are both 0.
- R10: A `core_fetch` while `core_enabled` is low consumes nothing, and `core_insn` is the filler word.
- R11: `halt_req` while halted and `resume_cmd` while running have no effect on `core_force`, `halted` or `busy`.
- R12: A synchronous reset in any state empties the queue, drops `core_force` and returns the block to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_word | input | 32 | Instruction word offered by the host |
| host_valid | input | 1 | Host word is valid |
| host_ready | output | 1 | Block can accept a word this cycle |
| halt_req | input | 1 | Host asks the core to halt |
| resume_cmd | input | 1 | Host asks the core to resume |
| halted | output | 1 | Core is confirmed in debug mode and idle for host words |
| busy | output | 1 | Entry or exit from debug mode in progress |
| core_force | output | 1 | Force request to the core's debug entry |
| core_enabled | input | 1 | Core reports debug mode active |
| core_insn | output | 32 | Instruction word presented to the core |
| core_fetch | input | 1 | Core consumes the presented word this cycle |

## Verification
The bench walks a table of words with varying gaps between fetch pulses. A design that popped on a level instead of a pulse, or that lost order, would hand back a wrong or repeated word. It fills the queue to the brim and offers one more word; an off-by-one in the full flag would store it, and that word would appear in place of the filler. It pushes words before a resume and checks the exit word comes only after them. A design that injected the exit word at once would release the core with work left undone. It also covers entry through a core breakpoint, fetches while the core is not halted, ignored commands in the wrong state, and reset during a halt. A design that kept force high or kept stale words would show them on the ports.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

  localparam int unsigned INSN_W = 32;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_HALTING,
    ST_HALTED,
    ST_EXIT_WAIT,
    ST_DRAIN
  } dbi_state_e;

endpackage

// File: rtl/dbi_queue.sv
module dbi_queue #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dbi_seq.sv
module dbi_seq
  import dbi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic resume_cmd,
  input  logic core_enabled,
  input  logic exit_taken,
  output logic force_o,
  output logic halted_o,
  output logic busy_o,
  output logic push_block_o,
  output logic exit_pend_o,
  output logic drain_o
);
  dbi_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_RUN: begin
        if (core_enabled)  st_nx = ST_HALTED;
        else if (halt_req) st_nx = ST_HALTING;
      end
      ST_HALTING:   if (core_enabled) st_nx = ST_HALTED;
      ST_HALTED:    if (resume_cmd)   st_nx = ST_EXIT_WAIT;
      ST_EXIT_WAIT: if (exit_taken)   st_nx = ST_DRAIN;
      ST_DRAIN:     if (!core_enabled) st_nx = ST_RUN;
      default:      st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_RUN;
    else     st <= st_nx;
  end

  assign force_o      = (st == ST_HALTING);
  assign halted_o     = (st == ST_HALTED);
  assign exit_pend_o  = (st == ST_EXIT_WAIT);
  assign drain_o      = (st == ST_DRAIN);
  assign push_block_o = exit_pend_o || drain_o;
  assign busy_o       = force_o || push_block_o;
endmodule

// File: rtl/dbi_word_sel.sv
module dbi_word_sel #(
  parameter int unsigned WIDTH     = 32,
  parameter logic [WIDTH-1:0] FILL_WORD = 32'h0000_0013,
  parameter logic [WIDTH-1:0] EXIT_WORD = 32'h0010_0073
) (
  input  logic             core_enabled,
  input  logic             core_fetch,
  input  logic             q_empty,
  input  logic [WIDTH-1:0] q_head,
  input  logic             exit_pend,
  input  logic             drain,
  output logic [WIDTH-1:0] core_insn,
  output logic             q_pop,
  output logic             exit_taken
);
  logic serving;

  assign serving = core_enabled && !drain;

  always_comb begin
    core_insn = FILL_WORD;
    if (serving) begin
      if (!q_empty)       core_insn = q_head;
      else if (exit_pend) core_insn = EXIT_WORD;
    end
  end

  assign q_pop      = serving && core_fetch && !q_empty;
  assign exit_taken = serving && core_fetch && q_empty && exit_pend;
endmodule

// File: rtl/dbg_inject_ctrl.sv
module dbg_inject_ctrl #(
  parameter int unsigned DEPTH     = 8,
  parameter logic [31:0] FILL_WORD = 32'h0000_0013,
  parameter logic [31:0] EXIT_WORD = 32'h0010_0073
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] host_word,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        halt_req,
  input  logic        resume_cmd,
  output logic        halted,
  output logic        busy,
  output logic        core_force,
  input  logic        core_enabled,
  output logic [31:0] core_insn,
  input  logic        core_fetch
);
  import dbi_pkg::*;

  logic [INSN_W-1:0] q_head;
  logic q_empty, q_full, q_push, q_pop;
  logic push_block, exit_pend, drain, exit_taken;

  assign host_ready = !q_full && !push_block;
  assign q_push     = host_valid && host_ready;

  dbi_queue #(.WIDTH(INSN_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .din(host_word), .pop(q_pop),
    .dout(q_head), .empty(q_empty), .full(q_full)
  );

  dbi_seq u_seq (
    .clk(clk), .rst(rst), .halt_req(halt_req), .resume_cmd(resume_cmd),
    .core_enabled(core_enabled), .exit_taken(exit_taken),
    .force_o(core_force), .halted_o(halted), .busy_o(busy),
    .push_block_o(push_block), .exit_pend_o(exit_pend), .drain_o(drain)
  );

  dbi_word_sel #(.WIDTH(INSN_W), .FILL_WORD(FILL_WORD), .EXIT_WORD(EXIT_WORD)) u_sel (
    .core_enabled(core_enabled), .core_fetch(core_fetch), .q_empty(q_empty),
    .q_head(q_head), .exit_pend(exit_pend), .drain(drain),
    .core_insn(core_insn), .q_pop(q_pop), .exit_taken(exit_taken)
  );
endmodule

// File: rtl/dbi_checker.sv
module dbi_checker #(
  parameter logic [31:0] FILL_WORD = 32'h0000_0013
) (
  input logic        clk,
  input logic        rst,
  input logic        host_ready,
  input logic        halted,
  input logic        busy,
  input logic        core_force,
  input logic        core_enabled,
  input logic [31:0] core_insn
);
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(halted && busy)); // R2
  AST_FORCE_HELD: assert property (@(posedge clk) disable iff (rst)
    (core_force && !core_enabled) |=> core_force); // R2
  AST_FORCE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    halted |-> !core_force); // R3
  AST_HALT_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(core_enabled)); // R3
  AST_NO_PUSH_LEAVING: assert property (@(posedge clk) disable iff (rst)
    (busy && !core_force) |-> !host_ready); // R8
  AST_RUN_NEEDS_DROP: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !halted) |-> !$past(core_enabled)); // R9
  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (rst)
    !core_enabled |-> (core_insn == FILL_WORD)); // R10
endmodule

bind dbg_inject_ctrl dbi_checker #(.FILL_WORD(FILL_WORD)) u_chk (
  .clk(clk), .rst(rst), .host_ready(host_ready), .halted(halted), .busy(busy),
  .core_force(core_force), .core_enabled(core_enabled), .core_insn(core_insn)
);

// File: tb/tb_dbg_inject_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_inject_ctrl;
  localparam logic [31:0] FILL = 32'h0000_0013;
  localparam logic [31:0] EXITW = 32'h0010_0073;
  localparam int DEPTH = 8;
  localparam int NVEC = 6;
  // {word, idle cycles before fetch}
  localparam logic [39:0] VEC [0:NVEC-1] = '{
    {32'h0000_0093, 8'd0}, {32'h0010_0113, 8'd3}, {32'hDEAD_BEEF, 8'd1},
    {32'h0020_8233, 8'd7}, {32'h0000_0000, 8'd0}, {32'hFFFF_FFFF, 8'd2}
  };

  logic clk = 0, rst = 1;
  logic [31:0] host_word = '0;
  logic host_valid = 0, halt_req = 0, resume_cmd = 0, core_enabled = 0, core_fetch = 0;
  logic host_ready, halted, busy, core_force;
  logic [31:0] core_insn;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_inject_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .host_word(host_word), .host_valid(host_valid),
    .host_ready(host_ready), .halt_req(halt_req), .resume_cmd(resume_cmd),
    .halted(halted), .busy(busy), .core_force(core_force),
    .core_enabled(core_enabled), .core_insn(core_insn), .core_fetch(core_fetch)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [31:0] w, output bit acc);
    @(negedge clk);
    host_valid = 1; host_word = w;
    #1 acc = host_ready;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic fetch_chk(string tag, logic [31:0] exp);
    @(negedge clk);
    core_fetch = 1;
    #1 chk(tag, core_insn, exp);
    @(negedge clk);
    core_fetch = 0;
  endtask

  task automatic pulse_halt();
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0;
  endtask

  task automatic pulse_resume();
    @(negedge clk); resume_cmd = 1;
    @(negedge clk); resume_cmd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    host_valid = 0; halt_req = 0; resume_cmd = 0; core_fetch = 0; core_enabled = 0;
    idle(3);
    rst = 0;
    #1;
  endtask

  task automatic leave();
    pulse_resume();
    fetch_chk("R8 exit word", EXITW);
    core_enabled = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit acc;
    do_reset();
    // R1 reset state
    chk("R1 host_ready", host_ready, 1);
    chk("R1 core_force", core_force, 0);
    chk("R1 halted", halted, 0);
    chk("R1 busy", busy, 0);
    chk("R1 core_insn", core_insn, FILL);

    // load table words while running
    for (int i = 0; i < NVEC; i++) begin
      push(VEC[i][39:8], acc);
      chk("R5 push accepted", acc, 1);
    end
    // R10 fetch while not enabled consumes nothing
    fetch_chk("R10 insn while running", FILL);

    // R2 halt via force
    pulse_halt();
    chk("R2 force", core_force, 1);
    chk("R2 busy", busy, 1);
    chk("R2 halted low", halted, 0);
    idle(3);
    chk("R2 force held", core_force, 1);
    core_enabled = 1;
    @(negedge clk);
    chk("R3 halted", halted, 1);
    chk("R3 force released", core_force, 0);

    // R5 table walk with variable gaps
    for (int i = 0; i < NVEC; i++) begin
      idle(int'(VEC[i][7:0]));
      fetch_chk("R5 queued word", VEC[i][39:8]);
    end
    // R6 empty queue filler
    fetch_chk("R6 filler", FILL);
    fetch_chk("R6 filler again", FILL);
    chk("R6 still halted", halted, 1);

    // R11 halt_req while halted
    pulse_halt();
    chk("R11 force stays low", core_force, 0);
    chk("R11 halted stays", halted, 1);

    // R7 full queue
    for (int i = 0; i < DEPTH; i++) begin
      push(32'h1000_0000 + i, acc);
      chk("R7 accepted below full", acc, 1);
    end
    chk("R7 ready low when full", host_ready, 0);
    push(32'hBAD0_0BAD, acc);
    chk("R7 refused when full", acc, 0);
    for (int i = 0; i < DEPTH; i++) fetch_chk("R7 order after fill", 32'h1000_0000 + i);
    fetch_chk("R7 extra word not stored", FILL);

    // R8 resume behind pending words
    push(32'h2000_0001, acc);
    push(32'h2000_0002, acc);
    pulse_resume();
    chk("R8 busy after resume", busy, 1);
    chk("R8 halted low after resume", halted, 0);
    chk("R8 ready low after resume", host_ready, 0);
    push(32'hBAD1_1BAD, acc);
    chk("R8 push refused while leaving", acc, 0);
    fetch_chk("R8 pending word 1", 32'h2000_0001);
    fetch_chk("R8 pending word 2", 32'h2000_0002);
    fetch_chk("R8 exit word last", EXITW);
    // R9 drain
    chk("R9 busy while draining", busy, 1);
    chk("R9 filler after exit", core_insn, FILL);
    idle(2);
    chk("R9 busy held", busy, 1);
    core_enabled = 0;
    @(negedge clk);
    chk("R9 busy cleared", busy, 0);
    chk("R9 halted cleared", halted, 0);
    chk("R9 ready back", host_ready, 1);

    // R11 resume while running
    pulse_resume();
    chk("R11 resume ignored busy", busy, 0);
    chk("R11 resume ignored halted", halted, 0);

    // R4 entry through core breakpoint
    @(negedge clk);
    core_enabled = 1;
    #1 chk("R4 no force", core_force, 0);
    @(negedge clk);
    chk("R4 halted", halted, 1);
    chk("R4 force still low", core_force, 0);
    leave();
    chk("R9 running after leave", busy, 0);

    // R12 reset mid-halt with words queued
    push(32'h3000_0001, acc);
    push(32'h3000_0002, acc);
    pulse_halt();
    chk("R12 pre-reset force", core_force, 1);
    do_reset();
    chk("R12 force low", core_force, 0);
    chk("R12 busy low", busy, 0);
    chk("R12 halted low", halted, 0);
    chk("R12 ready", host_ready, 1);
    core_enabled = 1;
    @(negedge clk);
    chk("R12 re-halted", halted, 1);
    fetch_chk("R12 queue emptied", FILL);
    leave();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule